// File: doc/BRIEF.md
# HDLC Frame Transmitter with Per-Buffer Events

This block turns a stream of tagged bytes from a FIFO read port into a bit-synchronous HDLC line signal, one bit per clock. A frame begins only when clear-to-send is high and the FIFO holds data. The block then sends one opening flag plus a programmable number of extra flags, followed by the frame bytes. Those bytes are two address bytes, a control byte and the information bytes, supplied in order by the FIFO. After the bytes it sends a 16-bit frame check sequence and a single closing flag. Zero insertion keeps flag patterns out of the frame body. Between frames the line rests at one.

Every byte carries two tags: one marks the end of a buffer and one marks the end of the frame. The block pulses a buffer event once per buffer. For an intermediate buffer, the pulse occurs when that buffer's final byte is taken from the FIFO. For the buffer that closes a frame, the pulse occurs together with the first bit of the closing flag. If the FIFO runs dry in the middle of a frame, the block sends an abort sequence and pulses an underrun event.

Top module: `hdlc_tx_buf_evt`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1 and both event outputs are 0. The line idles for at least one bit time between frames.
- R2: A frame starts only at a clock edge where `cts` and `fifo_valid` are both 1. In that cycle the line still shows 1, and the first flag bit follows on the next edge.
- R3: The frame opens with 1 + `extra_flags` flags of 0x7E, each sent least significant bit first, with no zero insertion inside them.
- R4: Byte bits go out least significant bit first. After five consecutive ones in the byte or check fields, a 0 is inserted. The ones count carries across byte boundaries and from the last data bit into the check field.
- R5: The check field is CRC-16 with the reflected polynomial 0x8408 and a preset of 0xFFFF, computed over the data bits. Its ones' complement is sent least significant bit first. For the ASCII string "123456789", the sent value is 0x906E.
- R6: After the check field, a pending inserted zero (if any) is sent, then one closing 0x7E flag, and then the line returns to idle.
- R7: For a byte tagged end-of-buffer but not end-of-frame, `buf_evt` pulses for one cycle at the same edge where that byte is taken.
- R8: For the end-of-frame buffer, `buf_evt` pulses for one cycle, aligned with the cycle in which `txd` shows the first bit of the closing flag.
- R9: A frame held in one buffer produces exactly one `buf_evt` pulse, however many bytes it contains.
- R10: If a further byte is needed but `fifo_valid` is 0, `underrun_evt` pulses at the edge that sends the last data bit. Eight ones follow, and then the line is idle.
- R11: Once a frame has started, dropping `cts` does not stop or change it.
- R12: `fifo_pop` is high exactly in cycles where a byte is taken. The first byte is taken with the last bit of the final opening flag. Each later byte is taken with the last regular bit of the previous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cts | input | 1 | Clear-to-send; gates the start of a frame |
| fifo_valid | input | 1 | FIFO holds a byte |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_buf_end | input | 1 | Head byte is the last of its buffer |
| fifo_frame_end | input | 1 | Head byte is the last of its frame |
| extra_flags | input | FLAGW | Opening flags beyond the first |
| fifo_pop | output | 1 | Head byte taken at this edge |
| txd | output | 1 | Serial line data |
| buf_evt | output | 1 | One-cycle buffer-sent event |
| underrun_evt | output | 1 | One-cycle underrun event |

## Verification
A wrong ones counter or shift position breaks the serial pattern within a few bits: a stray or missing inserted zero shifts every later bit, and `txd` diverges from the reference in that same cycle. A CRC register fault stays hidden until the check field, but then corrupts bits in the very first check cycle. Faults in event timing, such as a last-buffer event placed at byte take or an event emitted per byte, appear as a `buf_evt` mismatch in the exact cycle of the pulse. A FIFO handshake fault shows up on `fifo_pop` one cycle before the data bits that depend on it.

// File: rtl/hdlc_tx_buf_evt.sv
module hdlc_tx_buf_evt #(
  parameter int FLAGW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cts,
  input  logic             fifo_valid,
  input  logic [7:0]       fifo_data,
  input  logic             fifo_buf_end,
  input  logic             fifo_frame_end,
  input  logic [FLAGW-1:0] extra_flags,
  output logic             fifo_pop,
  output logic             txd,
  output logic             buf_evt,
  output logic             underrun_evt
);

  localparam logic [7:0]  FLAG   = 8'h7E;
  localparam logic [15:0] POLY   = 16'h8408;
  localparam logic [15:0] PRESET = 16'hFFFF;

  typedef enum logic [2:0] {S_IDLE, S_OPEN, S_DATA, S_CRC, S_CLOSE, S_ABORT} st_t;

  st_t              st;
  logic [15:0]      sh, crc;
  logic [3:0]       bcnt;
  logic [2:0]       ones;
  logic [FLAGW-1:0] fcnt;
  logic             last_q;

  wire bit_o  = sh[0];
  wire stuff  = (st == S_DATA || st == S_CRC || st == S_CLOSE) && ones == 3'd5;
  wire need_b = (st == S_OPEN && bcnt == 4'd7 && fcnt == '0) ||
                (st == S_DATA && !stuff && bcnt == 4'd7 && !last_q);
  wire [15:0] crc_nx = {1'b0, crc[15:1]} ^ ((crc[0] ^ bit_o) ? POLY : 16'h0);

  assign fifo_pop = need_b && fifo_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      txd <= 1'b1;
      buf_evt <= 1'b0;
      underrun_evt <= 1'b0;
      sh <= '0;
      crc <= PRESET;
      bcnt <= '0;
      ones <= '0;
      fcnt <= '0;
      last_q <= 1'b0;
    end else begin
      buf_evt <= 1'b0;
      underrun_evt <= 1'b0;
      case (st)
        S_IDLE: begin
          txd <= 1'b1;
          if (cts && fifo_valid) begin
            st <= S_OPEN;
            sh <= {8'h00, FLAG};
            bcnt <= '0;
            fcnt <= extra_flags;
            ones <= '0;
            crc <= PRESET;
          end
        end
        S_OPEN: begin
          txd <= bit_o;
          sh <= sh >> 1;
          bcnt <= bcnt + 4'd1;
          if (bcnt == 4'd7) begin
            bcnt <= '0;
            if (fcnt != '0) begin
              fcnt <= fcnt - 1'b1;
              sh <= {8'h00, FLAG};
            end else if (fifo_valid) begin
              sh <= {8'h00, fifo_data};
              last_q <= fifo_frame_end;
              buf_evt <= fifo_buf_end && !fifo_frame_end;
              st <= S_DATA;
            end else begin
              st <= S_ABORT;
              underrun_evt <= 1'b1;
            end
          end
        end
        S_DATA, S_CRC: begin
          if (stuff) begin
            txd <= 1'b0;
            ones <= '0;
          end else begin
            txd <= bit_o;
            ones <= bit_o ? ones + 3'd1 : 3'd0;
            sh <= sh >> 1;
            bcnt <= bcnt + 4'd1;
            if (st == S_DATA) begin
              crc <= crc_nx;
              if (bcnt == 4'd7) begin
                bcnt <= '0;
                if (last_q) begin
                  st <= S_CRC;
                  sh <= ~crc_nx;
                end else if (fifo_valid) begin
                  sh <= {8'h00, fifo_data};
                  last_q <= fifo_frame_end;
                  buf_evt <= fifo_buf_end && !fifo_frame_end;
                end else begin
                  st <= S_ABORT;
                  underrun_evt <= 1'b1;
                end
              end
            end else if (bcnt == 4'd15) begin
              st <= S_CLOSE;
              sh <= {8'h00, FLAG};
              bcnt <= '0;
            end
          end
        end
        S_CLOSE: begin
          if (stuff) begin
            txd <= 1'b0;
            ones <= '0;
          end else begin
            txd <= bit_o;
            sh <= sh >> 1;
            bcnt <= bcnt + 4'd1;
            if (bcnt == 4'd0) buf_evt <= 1'b1;
            if (bcnt == 4'd7) begin
              st <= S_IDLE;
              bcnt <= '0;
            end
          end
        end
        S_ABORT: begin
          txd <= 1'b1;
          bcnt <= bcnt + 4'd1;
          if (bcnt == 4'd7) begin
            st <= S_IDLE;
            bcnt <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |=> txd);

  a_r2_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !cts) |=> st == S_IDLE);

  a_r4_stuffed_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_DATA || st == S_CRC) && ones == 3'd5) |=> !txd);

  a_r8_last_evt_on_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_evt && st == S_CLOSE) |-> !txd);

  a_r10_abort_ones: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_evt |=> txd);

  a_r7_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_evt && underrun_evt));

endmodule

// File: tb/test_hdlc_tx_buf_evt.sv
module test_hdlc_tx_buf_evt;
  localparam int FLAGW = 4;

  logic clk = 1'b0, rst_n = 1'b0, cts = 1'b0, fifo_valid = 1'b0;
  logic [7:0] fifo_data = '0;
  logic fifo_buf_end = 1'b0, fifo_frame_end = 1'b0;
  logic [FLAGW-1:0] extra_flags = '0;
  logic fifo_pop, txd, buf_evt, underrun_evt;

  hdlc_tx_buf_evt #(.FLAGW(FLAGW)) i_hdlc_tx_buf_evt (
    .clk(clk), .rst_n(rst_n), .cts(cts), .fifo_valid(fifo_valid),
    .fifo_data(fifo_data), .fifo_buf_end(fifo_buf_end),
    .fifo_frame_end(fifo_frame_end), .extra_flags(extra_flags),
    .fifo_pop(fifo_pop), .txd(txd), .buf_evt(buf_evt),
    .underrun_evt(underrun_evt));

  always #10 clk = ~clk;

  typedef struct { bit b; bit pop; bit bev; bit uev; string req; string ereq; } item_t;
  typedef struct { logic [7:0] d; bit be; bit fe; } byte_t;

  item_t mq[$];
  byte_t sq[$];
  item_t ex;
  bit armed = 0;
  bit done = 0;
  int total = 0, bad = 0;
  int obs_bev = 0, obs_uev = 0;
  bit cts_w = 0;
  int extra_w = 0;

  task automatic chk(bit ok, string req, int act, int exp, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic item_t mk(bit b, string req, string ereq);
    item_t it;
    it.b = b; it.pop = 0; it.bev = 0; it.uev = 0; it.req = req; it.ereq = ereq;
    return it;
  endfunction

  function automatic logic [15:0] crc_step(logic [15:0] c, bit b);
    return (c >> 1) ^ ((c[0] ^ b) ? 16'h8408 : 16'h0);
  endfunction

  // Builds the expected bit sequence of the next frame from the supply queue
  function automatic void build();
    int ones = 0;
    logic [15:0] c = 16'hFFFF;
    int idx = 0;
    int nfl = extra_w + 1;
    logic [15:0] v;
    for (int f = 0; f < nfl; f++)
      for (int j = 0; j < 8; j++) begin
        item_t it = mk(bit'((8'h7E >> j) & 1), "R3", "R7");
        if (f == nfl - 1 && j == 7) begin
          it.pop = 1;
          it.bev = sq[0].be && !sq[0].fe;
        end
        mq.push_back(it);
      end
    forever begin
      byte_t cur = sq[idx];
      for (int j = 0; j < 8; j++) begin
        item_t it;
        if (ones == 5) begin mq.push_back(mk(0, "R4", "R7")); ones = 0; end
        it = mk(cur.d[j], "R4", "R7");
        c = crc_step(c, cur.d[j]);
        ones = cur.d[j] ? ones + 1 : 0;
        if (j == 7 && !cur.fe) begin
          if (idx + 1 < sq.size()) begin
            it.pop = 1;
            it.bev = sq[idx+1].be && !sq[idx+1].fe;
          end else begin
            it.uev = 1;
            it.req = "R10";
          end
        end
        mq.push_back(it);
      end
      if (cur.fe) break;
      if (idx + 1 >= sq.size()) begin
        for (int k = 0; k < 8; k++) mq.push_back(mk(1, "R10", "R10"));
        return;
      end
      idx++;
    end
    v = ~c;
    for (int j = 0; j < 16; j++) begin
      if (ones == 5) begin mq.push_back(mk(0, "R4", "R7")); ones = 0; end
      mq.push_back(mk(v[j], "R5", "R7"));
      ones = v[j] ? ones + 1 : 0;
    end
    if (ones == 5) mq.push_back(mk(0, "R6", "R7"));
    for (int j = 0; j < 8; j++) begin
      item_t it = mk(bit'((8'h7E >> j) & 1), "R6", "R8");
      it.bev = (j == 0);
      mq.push_back(it);
    end
  endfunction

  task automatic plan_next();
    item_t nx;
    cts = cts_w;
    extra_flags = FLAGW'(extra_w);
    fifo_valid = sq.size() > 0;
    if (sq.size() > 0) begin
      fifo_data = sq[0].d; fifo_buf_end = sq[0].be; fifo_frame_end = sq[0].fe;
    end else begin
      fifo_data = '0; fifo_buf_end = 0; fifo_frame_end = 0;
    end
    #1;
    if (mq.size() > 0) nx = mq.pop_front();
    else begin
      nx = mk(1, cts ? "R1" : "R2", "R1");
      if (cts && sq.size() > 0) build();
    end
    chk(fifo_pop == nx.pop, "R12", fifo_pop, nx.pop, "fifo_pop");
    ex = nx;
    armed = 1;
  endtask

  task automatic cyc();
    @(negedge clk);
    if (armed) begin
      chk(txd == ex.b, ex.req, txd, ex.b, "txd");
      chk(buf_evt == ex.bev, ex.ereq, buf_evt, ex.bev, "buf_evt");
      chk(underrun_evt == ex.uev, "R10", underrun_evt, ex.uev, "underrun_evt");
      if (buf_evt) obs_bev++;
      if (underrun_evt) obs_uev++;
      if (ex.pop) void'(sq.pop_front());
    end
    plan_next();
  endtask

  task automatic push(logic [7:0] d, bit be, bit fe);
    byte_t x; x.d = d; x.be = be; x.fe = fe;
    sq.push_back(x);
  endtask

  task automatic drain();
    while (mq.size() > 0 || sq.size() > 0) cyc();
    repeat (3) cyc();
  endtask

  function automatic logic [15:0] fcs_of(string s);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < s.len(); i++)
      for (int j = 0; j < 8; j++) c = crc_step(c, s[i][j]);
    return ~c;
  endfunction

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int b0, u0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(txd == 1 && !buf_evt && !underrun_evt, "R1", {txd, buf_evt, underrun_evt}, 3'b100, "reset outputs");
    // R5 known answer for the check sequence
    chk(fcs_of("123456789") == 16'h906E, "R5", fcs_of("123456789"), 16'h906E, "fcs");
    rst_n = 1;
    plan_next();

    // R2: data waiting without clear-to-send keeps the line idle
    push(8'hFF, 0, 0); push(8'hFF, 0, 0); push(8'h03, 1, 0);
    push(8'h3F, 0, 0); push(8'hFE, 0, 0); push(8'h7E, 1, 1);
    repeat (20) cyc();
    cts_w = 1;
    b0 = obs_bev;
    drain();
    chk(obs_bev - b0 == 2, "R7", obs_bev - b0, 2, "two-buffer event count");

    // R9: single buffer, one extra flag
    extra_w = 1;
    push(8'hC1, 0, 0); push(8'hC1, 0, 0); push(8'h13, 0, 0);
    push(8'h55, 0, 0); push(8'hF8, 0, 0); push(8'h1F, 1, 1);
    b0 = obs_bev;
    drain();
    chk(obs_bev - b0 == 1, "R9", obs_bev - b0, 1, "single-buffer event count");

    // R11: cts dropped mid-frame
    extra_w = 3;
    push(8'h01, 0, 0); push(8'h02, 1, 0); push(8'h03, 0, 0);
    push(8'hAA, 1, 0); push(8'hFF, 0, 0); push(8'hFF, 1, 1);
    b0 = obs_bev;
    repeat (30) cyc();
    cts_w = 0;
    drain();
    chk(obs_bev - b0 == 3, "R11", obs_bev - b0, 3, "frame completes without cts");
    push(8'h11, 1, 1);
    repeat (15) cyc();
    chk(sq.size() == 1, "R2", sq.size(), 1, "no start while cts low");
    cts_w = 1;
    drain();

    // R10: underrun mid-frame
    extra_w = 0;
    push(8'hFF, 0, 0); push(8'hF7, 1, 0); push(8'h3E, 0, 0);
    u0 = obs_uev;
    drain();
    chk(obs_uev - u0 == 1, "R10", obs_uev - u0, 1, "underrun count");

    // R3 R4 R5 R6: mixed frames, back to back
    for (int f = 0; f < 8; f++) begin
      int n = 3 + (f % 5);
      extra_w = f % 3;
      for (int i = 0; i < n; i++) begin
        logic [7:0] d = (f % 2) ? 8'hFF ^ 8'($urandom_range(0, 7)) : 8'($urandom);
        push(d, (i == n - 1) || (i % 3 == 2), i == n - 1);
      end
    end
    drain();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule